// File: doc/BRIEF.md
# Configurable GPIO Pin Multiplexer

This block sits between a set of on-chip peripheral functions and a bank of IO pads. For every pad, a small selector picks either plain GPIO or one of three alternate functions. The block then forms the pad's output data, output enable and pull controls, and it can drive the pad as push-pull or as open-drain. A function that is bidirectional can take over the pad's direction and pull-up control while it is selected, so it does not need software to flip the GPIO direction bits.

On the receive side, each peripheral input has its own single-source selector. The selector names exactly one pad, or none. Because of this, two pads can never contend for one input, and an unrouted input rests at a configured idle level. The interrupt-capable pads pass through a synchronizer and a debouncer. The debouncer's sample rate and its hold count are programmable. All pad-to-function paths are combinational, so they add no latency. A write-only register port holds the configuration.

Top module: `gpio_pinmux`

## Requirements
- R1: After reset every pad is in GPIO mode with pad_oe, pad_out, pad_pu and pad_pd low, every fn_in is 0, and every eint_o is 0.
- R2: A write to address p (p below NPADS) sets the configuration of pad p. The data bits are: [1:0] select, [2] GPIO output enable, [3] GPIO output data, [4] pull-up request, [5] pull-down request, [6] open-drain. With select 0 the pad shows the GPIO data bit, the GPIO output enable bit and the requested pulls.
- R3: With select k (1 to 3), pad p carries the output data of function (p+k-1) mod NFUNC. Its output enable comes from the GPIO bit, unless fn_own of that function is high. In that case pad_oe follows fn_oe and pad_pu follows fn_pu of that function.
- R4: A single function output may be selected on several pads at once, and all of those pads then show it.
- R5: With the open-drain bit set, pad_out is 0. pad_oe is high when the selected data is 0 and low when the selected data is 1.
- R6: If pull-up and pull-down are both in effect, pad_pu is high and pad_pd is low.
- R7: A write to address NPADS+f sets the input route of function f. The data bits are: [2:0] pad index, [3] enable, [4] idle level. When the route is enabled, fn_in[f] equals pad_in of the indexed pad, and the other pads have no effect on it.
- R8: When the route of function f is disabled, fn_in[f] holds the idle level whatever the pads do.
- R9: A write to address NPADS+NFUNC sets the debouncer. The data bits are: [7:0] divider D, giving a sample tick every D+1 clocks, and [11:8] hold count N, where 0 acts as 1. After a two-flop synchronizer, eint_o[i] follows pad_in[i] only once the new level has been seen on N consecutive ticks. A shorter pulse leaves eint_o unchanged.
- R10: The pad outputs and fn_in follow changes of the function signals and pad inputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 12 | Configuration write data |
| fn_out | input | NFUNC | Output data from each function |
| fn_oe | input | NFUNC | Output enable requested by each function |
| fn_own | input | NFUNC | Function takes over direction and pull-up |
| fn_pu | input | NFUNC | Pull-up requested by each function |
| fn_in | output | NFUNC | Routed input to each function |
| pad_in | input | NPADS | Level seen at each pad |
| pad_out | output | NPADS | Data driven to each pad |
| pad_oe | output | NPADS | Output enable of each pad |
| pad_pu | output | NPADS | Pull-up enable of each pad |
| pad_pd | output | NPADS | Pull-down enable of each pad |
| eint_o | output | NEINT | Debounced interrupt-capable pad inputs |

## Verification
The output mux is driven with a table that covers every select value on one pad. Each entry sets the function data, enable, ownership and pull inputs to different values, so a wrong function index, a wrong ownership choice or a swapped field leads to a different result. Open-drain entries use both data levels, and pull entries request one pull and then both, to separate the drive style and the pull suppression from plain routing. Further tests select one function on three pads at once, move a pad index while other pads toggle, and compare a short glitch with a long hold under two divider settings so that the hold count is told apart from the sample rate.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;

  typedef struct packed {
    logic       od;
    logic       pd;
    logic       pu;
    logic       dout;
    logic       oe;
    logic [1:0] sel;
  } pad_cfg_t;

  localparam int PAD_CFG_W = $bits(pad_cfg_t);

endpackage

// File: rtl/pinmux_cfg_regs.sv
module pinmux_cfg_regs
  import pinmux_pkg::*;
#(
  parameter int NPADS  = 8,
  parameter int NFUNC  = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 12,
  parameter int PAD_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output pad_cfg_t [NPADS-1:0]          pad_q,
  output logic [NFUNC-1:0][PAD_W-1:0]   route_idx,
  output logic [NFUNC-1:0]              route_en,
  output logic [NFUNC-1:0]              route_idle,
  output logic [7:0]                    db_div,
  output logic [3:0]                    db_hold
);

  localparam int DB_ADDR = NPADS + NFUNC;

  pad_cfg_t [NPADS-1:0]        pad_d;
  logic [NFUNC-1:0][PAD_W-1:0] idx_d;
  logic [NFUNC-1:0]            en_d, idle_d;
  logic [7:0]                  div_d;
  logic [3:0]                  hold_d;

  always_comb begin
    pad_d  = pad_q;
    idx_d  = route_idx;
    en_d   = route_en;
    idle_d = route_idle;
    div_d  = db_div;
    hold_d = db_hold;
    if (we) begin
      for (int p = 0; p < NPADS; p++)
        if (int'(addr) == p) pad_d[p] = pad_cfg_t'(wdata[PAD_CFG_W-1:0]);
      for (int f = 0; f < NFUNC; f++)
        if (int'(addr) == NPADS + f) begin
          idx_d[f]  = wdata[PAD_W-1:0];
          en_d[f]   = wdata[3];
          idle_d[f] = wdata[4];
        end
      if (int'(addr) == DB_ADDR) begin
        div_d  = wdata[7:0];
        hold_d = wdata[11:8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q      <= '0;
      route_idx  <= '0;
      route_en   <= '0;
      route_idle <= '0;
      db_div     <= '0;
      db_hold    <= '0;
    end else begin
      pad_q      <= pad_d;
      route_idx  <= idx_d;
      route_en   <= en_d;
      route_idle <= idle_d;
      db_div     <= div_d;
      db_hold    <= hold_d;
    end
  end

endmodule

// File: rtl/pinmux_pad_out.sv
module pinmux_pad_out
  import pinmux_pkg::*;
#(
  parameter int NPADS = 8,
  parameter int NFUNC = 8
) (
  input  pad_cfg_t [NPADS-1:0] cfg,
  input  logic [NFUNC-1:0]     fn_out,
  input  logic [NFUNC-1:0]     fn_oe,
  input  logic [NFUNC-1:0]     fn_own,
  input  logic [NFUNC-1:0]     fn_pu,
  output logic [NPADS-1:0]     pad_out,
  output logic [NPADS-1:0]     pad_oe,
  output logic [NPADS-1:0]     pad_pu,
  output logic [NPADS-1:0]     pad_pd
);

  localparam int FW = (NFUNC > 1) ? $clog2(NFUNC) : 1;

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    localparam int FA = p % NFUNC;
    localparam int FB = (p + 1) % NFUNC;
    localparam int FC = (p + 2) % NFUNC;

    logic [FW-1:0] fi;
    logic          data_m, oe_m, pu_m;

    always_comb begin
      fi     = FW'(FA);
      data_m = cfg[p].dout;
      oe_m   = cfg[p].oe;
      pu_m   = cfg[p].pu;
      case (cfg[p].sel)
        2'd2:    fi = FW'(FB);
        2'd3:    fi = FW'(FC);
        default: fi = FW'(FA);
      endcase
      if (cfg[p].sel != 2'd0) begin
        data_m = fn_out[fi];
        if (fn_own[fi]) begin
          oe_m = fn_oe[fi];
          pu_m = fn_pu[fi];
        end
      end
      if (cfg[p].od) begin
        pad_out[p] = 1'b0;
        pad_oe[p]  = oe_m & ~data_m;
      end else begin
        pad_out[p] = data_m;
        pad_oe[p]  = oe_m;
      end
      pad_pu[p] = pu_m;
      pad_pd[p] = cfg[p].pd & ~pu_m;
    end
  end

endmodule

// File: rtl/pinmux_in_route.sv
module pinmux_in_route #(
  parameter int NPADS = 8,
  parameter int NFUNC = 8,
  parameter int PAD_W = 3
) (
  input  logic [NPADS-1:0]            pad_in,
  input  logic [NFUNC-1:0][PAD_W-1:0] route_idx,
  input  logic [NFUNC-1:0]            route_en,
  input  logic [NFUNC-1:0]            route_idle,
  output logic [NFUNC-1:0]            fn_in
);

  for (genvar f = 0; f < NFUNC; f++) begin : g_fn
    logic picked;
    always_comb begin
      picked = 1'b0;
      for (int p = 0; p < NPADS; p++)
        if (int'(route_idx[f]) == p) picked = pad_in[p];
      fn_in[f] = route_en[f] ? picked : route_idle[f];
    end
  end

endmodule

// File: rtl/pinmux_debounce.sv
module pinmux_debounce #(
  parameter int NEINT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NEINT-1:0] raw,
  input  logic [7:0]       div,
  input  logic [3:0]       hold,
  output logic [NEINT-1:0] deb
);

  logic [7:0]       pcnt_q, pcnt_d;
  logic             tick;
  logic [NEINT-1:0] s1_q, s2_q;
  logic [3:0]       hold_m1;

  assign tick    = (pcnt_q == div);
  assign pcnt_d  = tick ? 8'd0 : pcnt_q + 8'd1;
  assign hold_m1 = (hold == 4'd0) ? 4'd0 : hold - 4'd1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt_q <= '0;
      s1_q   <= '0;
      s2_q   <= '0;
    end else begin
      pcnt_q <= pcnt_d;
      s1_q   <= raw;
      s2_q   <= s1_q;
    end
  end

  for (genvar i = 0; i < NEINT; i++) begin : g_ch
    logic [3:0] cnt_q, cnt_d;
    logic       out_d;

    always_comb begin
      cnt_d = cnt_q;
      out_d = deb[i];
      if (tick) begin
        if (s2_q[i] == deb[i]) begin
          cnt_d = '0;
        end else if (cnt_q >= hold_m1) begin
          out_d = s2_q[i];
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 4'd1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q  <= '0;
        deb[i] <= 1'b0;
      end else begin
        cnt_q  <= cnt_d;
        deb[i] <= out_d;
      end
    end

    // R9: output moves only on a tick and only to the synchronized level
    a_r9_deb_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(deb[i]) |-> ($past(tick) && ($past(s2_q[i]) == deb[i])));
  end

endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux
  import pinmux_pkg::*;
#(
  parameter int NPADS  = 8,
  parameter int NFUNC  = 8,
  parameter int NEINT  = 2,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [NFUNC-1:0]  fn_out,
  input  logic [NFUNC-1:0]  fn_oe,
  input  logic [NFUNC-1:0]  fn_own,
  input  logic [NFUNC-1:0]  fn_pu,
  output logic [NFUNC-1:0]  fn_in,
  input  logic [NPADS-1:0]  pad_in,
  output logic [NPADS-1:0]  pad_out,
  output logic [NPADS-1:0]  pad_oe,
  output logic [NPADS-1:0]  pad_pu,
  output logic [NPADS-1:0]  pad_pd,
  output logic [NEINT-1:0]  eint_o
);

  localparam int PAD_W = (NPADS > 1) ? $clog2(NPADS) : 1;

  logic                        rst_s1_q, rst_s_n;
  pad_cfg_t [NPADS-1:0]        pad_cfg;
  logic [NFUNC-1:0][PAD_W-1:0] route_idx;
  logic [NFUNC-1:0]            route_en, route_idle;
  logic [7:0]                  db_div;
  logic [3:0]                  db_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s_n  <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s_n  <= rst_s1_q;
    end
  end

  pinmux_cfg_regs #(
    .NPADS(NPADS), .NFUNC(NFUNC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAD_W(PAD_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_s_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .pad_q(pad_cfg), .route_idx(route_idx), .route_en(route_en),
    .route_idle(route_idle), .db_div(db_div), .db_hold(db_hold)
  );

  pinmux_pad_out #(.NPADS(NPADS), .NFUNC(NFUNC)) u_out (
    .cfg(pad_cfg), .fn_out(fn_out), .fn_oe(fn_oe), .fn_own(fn_own), .fn_pu(fn_pu),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd)
  );

  pinmux_in_route #(.NPADS(NPADS), .NFUNC(NFUNC), .PAD_W(PAD_W)) u_in (
    .pad_in(pad_in), .route_idx(route_idx), .route_en(route_en),
    .route_idle(route_idle), .fn_in(fn_in)
  );

  pinmux_debounce #(.NEINT(NEINT)) u_deb (
    .clk(clk), .rst_n(rst_s_n), .raw(pad_in[NEINT-1:0]),
    .div(db_div), .hold(db_hold), .deb(eint_o)
  );

  for (genvar p = 0; p < NPADS; p++) begin : g_chk_pad
    // R5: an open-drain pad never drives high
    a_r5_od_no_high: assert property (@(posedge clk) disable iff (!rst_s_n)
      (pad_cfg[p].od && pad_oe[p]) |-> !pad_out[p]);
    // R6: both pulls never enabled together
    a_r6_pull_excl: assert property (@(posedge clk) disable iff (!rst_s_n)
      !(pad_pu[p] && pad_pd[p]));
  end

  for (genvar f = 0; f < NFUNC; f++) begin : g_chk_fn
    // R8: an unrouted function input rests at its idle level
    a_r8_idle_level: assert property (@(posedge clk) disable iff (!rst_s_n)
      !route_en[f] |-> (fn_in[f] == route_idle[f]));
    // R7: a routed function input follows its single chosen pad
    a_r7_single_src: assert property (@(posedge clk) disable iff (!rst_s_n)
      (route_en[f] && (int'(route_idx[f]) < NPADS)) |-> (fn_in[f] == pad_in[route_idx[f]]));
  end

endmodule

// File: tb/sim_gpio_pinmux.sv
`timescale 1ns/1ps
module sim_gpio_pinmux;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [11:0] cfg_wdata;
  logic [7:0]  fn_out, fn_oe, fn_own, fn_pu, fn_in;
  logic [7:0]  pad_in, pad_out, pad_oe, pad_pu, pad_pd;
  logic [1:0]  eint_o;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  gpio_pinmux u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .fn_out(fn_out), .fn_oe(fn_oe), .fn_own(fn_own), .fn_pu(fn_pu), .fn_in(fn_in),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .eint_o(eint_o)
  );

  // {pad2 cfg, fn_out, fn_oe, fn_own, fn_pu, expected {out,oe,pu,pd}}
  localparam logic [47:0] VEC [12] = '{
    {12'h00C, 8'h00, 8'h00, 8'h00, 8'h00, 4'b1100},  // R2 gpio drive high
    {12'h030, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0010},  // R6 both pulls
    {12'h020, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0001},  // R2 pull-down only
    {12'h005, 8'h04, 8'h00, 8'h00, 8'h00, 4'b1100},  // R3 alt1, gpio oe
    {12'h001, 8'h04, 8'h04, 8'h04, 8'h04, 4'b1110},  // R3 alt1, owned
    {12'h002, 8'hF7, 8'h00, 8'h08, 8'h00, 4'b0000},  // R3 alt2, owned off
    {12'h007, 8'h10, 8'h00, 8'h00, 8'h00, 4'b1100},  // R3 alt3
    {12'h047, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0100},  // R5 od data 0
    {12'h047, 8'h10, 8'h00, 8'h00, 8'h00, 4'b0000},  // R5 od data 1
    {12'h04C, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0000},  // R5 od gpio 1
    {12'h044, 8'h00, 8'h00, 8'h00, 8'h00, 4'b0100},  // R5 od gpio 0
    {12'h023, 8'h00, 8'h00, 8'h10, 8'h10, 4'b0010}   // R6 owned pu beats pd
  };

  function automatic string vtag(int i);
    case (i)
      0, 2:          return "R2";
      1, 11:         return "R6";
      7, 8, 9, 10:   return "R5";
      default:       return "R3";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [11:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #300000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    fn_out = '0; fn_oe = '0; fn_own = '0; fn_pu = '0; pad_in = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(4);

    // R1 reset state
    chk("R1", {pad_out, pad_oe, pad_pu, pad_pd}, 32'h0);
    chk("R1", {fn_in, 6'b0, eint_o}, 32'h0);

    // table walk on pad 2
    for (int i = 0; i < 12; i++) begin
      wr(5'd2, VEC[i][47:36]);
      fn_out = VEC[i][35:28]; fn_oe = VEC[i][27:20];
      fn_own = VEC[i][19:12]; fn_pu = VEC[i][11:4];
      #1;
      chk(vtag(i), {pad_out[2], pad_oe[2], pad_pu[2], pad_pd[2]}, VEC[i][3:0]);
    end

    // R4: function 2 on pads 0 (alt3), 1 (alt2), 2 (alt1)
    wr(5'd0, 12'h003); wr(5'd1, 12'h002); wr(5'd2, 12'h001);
    fn_out = 8'h04; fn_oe = 8'h04; fn_own = 8'h04; fn_pu = 8'h00;
    #1;
    chk("R4", {pad_out[2:0], pad_oe[2:0]}, 32'h3F);
    // R10: no clock edge between change and sample
    @(posedge clk); #1;
    fn_out = 8'h00;
    #0.5;
    chk("R10", pad_out[2:0], 32'h0);
    fn_out = 8'h04;
    #0.5;
    chk("R10", pad_out[2:0], 32'h7);

    // R7: function 5 from pad 3
    wr(5'd13, 12'h00B);
    pad_in = 8'h08; #1;
    chk("R7", fn_in[5], 32'h1);
    pad_in = 8'hF7; #1;
    chk("R7", fn_in[5], 32'h0);
    // R10: route follows the pad without a clock edge
    pad_in = 8'h08; #0.5;
    chk("R10", fn_in[5], 32'h1);

    // R8: function 6 disabled, idle 1; function 0 idle 0
    wr(5'd14, 12'h010);
    pad_in = 8'hFF; #1;
    chk("R8", {fn_in[6], fn_in[0]}, 32'h2);
    pad_in = 8'h00; #1;
    chk("R8", {fn_in[6], fn_in[0]}, 32'h2);

    // R9: divider 0, hold 4
    wr(5'd16, 12'h400);
    cycles(4);
    pad_in[0] = 1'b1; cycles(2); pad_in[0] = 1'b0;
    cycles(20);
    chk("R9", eint_o[0], 32'h0);
    pad_in[0] = 1'b1;
    cycles(3);
    chk("R9", eint_o[0], 32'h0);
    cycles(12);
    chk("R9", eint_o[0], 32'h1);

    // R9: divider 3, hold 2 on channel 1
    wr(5'd16, 12'h203);
    cycles(4);
    pad_in[1] = 1'b1;
    cycles(4);
    chk("R9", eint_o[1], 32'h0);
    cycles(16);
    chk("R9", eint_o[1], 32'h1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule